// File: doc/BRIEF.md
# ADC Result Register Sequencer

This block takes digitized samples from an abstracted converter and stores them in a file of result registers. Software programs a sequence length and a placement mode. It then issues a start, and the block counts accepted results, steers each one to a register, and raises a completion flag when the programmed number of results has arrived. Every register carries a flag that marks fresh data. Reading a register through the read port clears its flag, and a new start clears all of them.

There are two placement modes. In indexed mode the write pointer returns to register 0 at every sequence boundary, so result k of a sequence always lands in register k. In ring mode the pointer keeps running across sequence boundaries and wraps from the last register to register 0. An abort or a new start still returns it to 0. While ring mode is on, the compare enables passed on to a downstream compare unit are forced to zero. A freeze input stalls intake without losing the pointer position.

Results arrive on a valid/ready stream. A beat transfers on a clock edge where `res_valid` and `res_ready` are both high. `res_ready` is high only while a sequence is running, freeze is low, and neither start nor abort is asserted. The converter must hold `res_valid` and `res_data` stable until the beat transfers. All other pins are plain levels or single-cycle pulses.

Top module: `adc_result_seq`

## Requirements
- R1: After reset the length field reads as 4, indexed mode is selected, conv_cnt is 0, all done_flags are 0, seq_done is 0 and busy is 0. A sequence started without any configuration write completes after exactly 4 results.
- R2: In indexed mode (cfg_fifo=0), the k-th result of a sequence (counting from 0) is written to register k. After the last result conv_cnt returns to 0.
- R3: conv_cnt always equals the index of the register that the next accepted result will be written to.
- R4: A length field of 0 means 16 results per sequence. Values 1 to 15 mean that many results.
- R5: In ring mode (cfg_fifo=1), conv_cnt is not reset at sequence boundaries. It advances by one per accepted result and wraps from 15 to 0.
- R6: An abort or a start clears conv_cnt to 0 in either mode. A start also clears all done_flags and seq_done and sets busy. An abort clears busy and leaves done_flags unchanged. When both are asserted, the abort takes effect.
- R7: done_flags bit n sets in the cycle after register n is written. rd_en with rd_addr=n clears bit n one cycle later. When a write and a read hit the same register in the same cycle, the bit stays set.
- R8: seq_done sets when the last result of a sequence is stored. If scan is 1 in that cycle, busy stays 1 and the next sequence begins at once. Otherwise busy falls to 0.
- R9: cmp_en_eff equals cmp_en while the stored mode is indexed, and is all zero while the stored mode is ring.
- R10: While freeze is 1, res_ready is 0 and conv_cnt holds its value. When freeze falls, sequencing continues from that same value.
- R11: A result is stored only on a cycle where res_valid and res_ready are both 1. A valid beat offered while idle changes neither conv_cnt nor done_flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load cfg_len and cfg_fifo into the control register |
| cfg_len | input | 4 | Sequence length code (0 means 16) |
| cfg_fifo | input | 1 | 1 selects ring placement, 0 selects indexed placement |
| start | input | 1 | Pulse: begin a new sequence |
| abort | input | 1 | Pulse: stop the running sequence |
| scan | input | 1 | Restart automatically after each sequence completes |
| freeze | input | 1 | Stall intake while high |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | Block accepts a result this cycle |
| res_data | input | 12 | Converter result word |
| rd_en | input | 1 | Read strobe; clears the addressed flag |
| rd_addr | input | 4 | Result register to read |
| rd_data | output | 12 | Contents of the addressed register (combinational) |
| cmp_en | input | 16 | Requested compare enables, one per register |
| cmp_en_eff | output | 16 | Compare enables after the ring-mode override |
| conv_cnt | output | 4 | Index of the next register to be written |
| done_flags | output | 16 | Per-register fresh-data flags |
| seq_done | output | 1 | Sequence complete |
| busy | output | 1 | A sequence is running |

## Verification
On every cycle the assertions check the following: the pointer returns to zero after a start or an abort, and it does not move while frozen. Ready is low during freeze. A transfer always leaves the flag of the targeted register set. An indexed sequence ends with the pointer at zero. The busy level after completion matches the scan input, and the compare enables read as zero in ring mode. Other behaviour only shows up when the bench drives whole scenarios and compares them against its reference model. This covers where each data word lands across many beats, the length decoding including the 16-result case, the ring wrap after sixteen results, the reset length of four, and read-clear against write-set on the same cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned DEF_NREG = 16;
  localparam int unsigned DEF_DW   = 12;
  localparam int unsigned DEF_LEN  = 4;
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg #(
  parameter int unsigned CW      = 4,
  parameter int unsigned LEN_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_len,
  input  logic          cfg_fifo,
  output logic [CW-1:0] len_q,
  output logic          fifo_q
);
  localparam logic [CW-1:0] LEN_INIT = CW'(LEN_RST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= LEN_INIT;
      fifo_q <= 1'b0;
    end else if (cfg_we) begin
      len_q  <= cfg_len;
      fifo_q <= cfg_fifo;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned NREG = 16,
  parameter int unsigned CW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          scan,
  input  logic          freeze,
  input  logic          res_valid,
  input  logic [CW-1:0] len_q,
  input  logic          fifo_q,
  output logic          res_ready,
  output logic          wr_en,
  output logic [CW-1:0] cnt_q,
  output logic          busy_q,
  output logic          done_q
);
  localparam int unsigned  FULL = NREG;
  localparam logic [CW:0]  LEN_FULL = FULL[CW:0];
  localparam logic [CW-1:0] LAST_IDX = CW'(NREG - 1);

  logic [CW-1:0] pos_q;
  logic [CW:0]   len_eff;
  logic          last_beat;
  logic [CW-1:0] cnt_inc;

  always_comb begin
    len_eff   = (len_q == '0) ? LEN_FULL : {1'b0, len_q};
    last_beat = ({1'b0, pos_q} == (len_eff - 1'b1));
    cnt_inc   = (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
    res_ready = busy_q && !freeze && !start && !abort;
    wr_en     = res_valid && res_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pos_q  <= '0;
      cnt_q  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      pos_q  <= '0;
      cnt_q  <= '0;
    end else if (wr_en) begin
      if (last_beat) begin
        pos_q  <= '0;
        done_q <= 1'b1;
        busy_q <= scan;
        cnt_q  <= fifo_q ? cnt_inc : '0;
      end else begin
        pos_q <= pos_q + 1'b1;
        cnt_q <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/adc_seq_regfile.sv
module adc_seq_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 12,
  parameter int unsigned CW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            clr_all,
  input  logic            rd_en,
  input  logic [CW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [NREG-1:0] flags
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flag
    logic hit_wr, hit_rd;
    assign hit_wr = wr_en && (wr_idx == CW'(g));
    assign hit_rd = rd_en && (rd_addr == CW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) flags[g] <= 1'b0;
      else if (hit_wr)       flags[g] <= 1'b1;
      else if (hit_rd)       flags[g] <= 1'b0;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/adc_result_seq.sv
module adc_result_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned NREG = DEF_NREG,
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned RLEN = DEF_LEN,
  localparam int unsigned CW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CW-1:0]   cfg_len,
  input  logic            cfg_fifo,
  input  logic            start,
  input  logic            abort,
  input  logic            scan,
  input  logic            freeze,
  input  logic            res_valid,
  output logic            res_ready,
  input  logic [DW-1:0]   res_data,
  input  logic            rd_en,
  input  logic [CW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [NREG-1:0] cmp_en,
  output logic [NREG-1:0] cmp_en_eff,
  output logic [CW-1:0]   conv_cnt,
  output logic [NREG-1:0] done_flags,
  output logic            seq_done,
  output logic            busy
);
  logic [CW-1:0] len_q;
  logic          fifo_q;
  logic          wr_en;

  adc_seq_cfg #(.CW(CW), .LEN_RST(RLEN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_fifo(cfg_fifo), .len_q(len_q), .fifo_q(fifo_q)
  );

  adc_seq_ctrl #(.NREG(NREG), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .scan(scan),
    .freeze(freeze), .res_valid(res_valid), .len_q(len_q), .fifo_q(fifo_q),
    .res_ready(res_ready), .wr_en(wr_en), .cnt_q(conv_cnt),
    .busy_q(busy), .done_q(seq_done)
  );

  adc_seq_regfile #(.NREG(NREG), .DW(DW), .CW(CW)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(conv_cnt),
    .wr_data(res_data), .clr_all(start && !abort), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .flags(done_flags)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign cmp_en_eff[g] = cmp_en[g] && !fifo_q;
  end
endmodule

// File: rtl/adc_result_seq_chk.sv
module adc_result_seq_chk #(
  parameter int unsigned NREG = 16,
  parameter int unsigned CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            abort,
  input logic            scan,
  input logic            freeze,
  input logic            res_valid,
  input logic            res_ready,
  input logic            fifo_q,
  input logic [NREG-1:0] cmp_en_eff,
  input logic [CW-1:0]   conv_cnt,
  input logic [NREG-1:0] done_flags,
  input logic            seq_done,
  input logic            busy
);
  p_cnt_clear_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start || abort) |=> (conv_cnt == '0));

  p_busy_after_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  p_ready_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !res_ready);

  p_cnt_hold_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !start && !abort) |=> $stable(conv_cnt));

  p_flag_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> done_flags[$past(conv_cnt)]);

  p_busy_vs_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> (busy == $past(scan)));

  p_index_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(seq_done) && !$past(fifo_q)) |-> (conv_cnt == '0));

  p_cmp_off_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_q |-> (cmp_en_eff == '0));
endmodule

bind adc_result_seq adc_result_seq_chk #(.NREG(NREG), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .scan(scan),
  .freeze(freeze), .res_valid(res_valid), .res_ready(res_ready),
  .fifo_q(fifo_q), .cmp_en_eff(cmp_en_eff), .conv_cnt(conv_cnt),
  .done_flags(done_flags), .seq_done(seq_done), .busy(busy)
);

// File: tb/adc_result_seq_bench.sv
`timescale 1ns/1ps
module adc_result_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_fifo = 0, start = 0, abort = 0, scan = 0, freeze = 0;
  logic [3:0] cfg_len = 0, rd_addr = 0;
  logic res_valid = 0, rd_en = 0;
  logic [11:0] res_data = 0;
  logic [15:0] cmp_en = 0;
  logic res_ready, seq_done, busy;
  logic [11:0] rd_data;
  logic [15:0] cmp_en_eff, done_flags;
  logic [3:0] conv_cnt;

  int total = 0, bad = 0, cycles = 0;
  bit ended = 0;

  int m_cnt, m_pos, m_len, m_ccf[16], m_reg[16];
  bit m_busy, m_done, m_fifo;

  always #4 clk = ~clk;

  adc_result_seq u_adc_result_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_fifo(cfg_fifo), .start(start), .abort(abort), .scan(scan),
    .freeze(freeze), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp_en(cmp_en), .cmp_en_eff(cmp_en_eff), .conv_cnt(conv_cnt),
    .done_flags(done_flags), .seq_done(seq_done), .busy(busy)
  );

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  // Reference model, advanced on every rising edge
  always @(posedge clk) begin
    int nl, wi;
    bit rdy, acc;
    if (!rst_n) begin
      m_cnt = 0; m_pos = 0; m_len = 4; m_busy = 0; m_done = 0; m_fifo = 0;
      for (int i = 0; i < 16; i++) begin m_ccf[i] = 0; m_reg[i] = 0; end
    end else begin
      rdy = m_busy && !freeze && !start && !abort;
      acc = rdy && res_valid;
      wi = m_cnt;
      nl = (m_len == 0) ? 16 : m_len;
      if (rd_en) m_ccf[rd_addr] = 0;
      if (abort) begin
        m_cnt = 0; m_pos = 0; m_busy = 0;
      end else if (start) begin
        m_cnt = 0; m_pos = 0; m_busy = 1; m_done = 0;
        for (int i = 0; i < 16; i++) m_ccf[i] = 0;
      end else if (acc) begin
        m_reg[wi] = res_data;
        m_ccf[wi] = 1;
        if (m_pos == nl - 1) begin
          m_pos = 0; m_done = 1; m_busy = scan;
          m_cnt = m_fifo ? (m_cnt + 1) % 16 : 0;
        end else begin
          m_pos++; m_cnt = (m_cnt + 1) % 16;
        end
      end
      if (cfg_we) begin m_len = cfg_len; m_fifo = cfg_fifo; end
    end
  end

  // Per-cycle comparison against the model, mid-cycle
  always @(negedge clk) begin
    int f;
    if (rst_n && !ended) begin
      f = 0;
      for (int i = 0; i < 16; i++) f |= (m_ccf[i] << i);
      chk("R3 conv_cnt", conv_cnt, m_cnt);
      chk("R7 done_flags", done_flags, f);
      chk("R8 seq_done", seq_done, m_done);
      chk("R8 busy", busy, m_busy);
      chk("R10 res_ready", res_ready, m_busy && !freeze && !start && !abort);
      chk("R2 rd_data", rd_data, m_reg[rd_addr]);
      chk("R9 cmp_en_eff", cmp_en_eff, m_fifo ? 0 : cmp_en);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_start();
    start = 1; step(); start = 0;
  endtask

  task automatic pulse_abort();
    abort = 1; step(); abort = 0;
  endtask

  task automatic config_set(int len, bit fifo);
    cfg_len = len[3:0]; cfg_fifo = fifo; cfg_we = 1; step(); cfg_we = 0;
  endtask

  task automatic feed(int n, int base);
    for (int k = 0; k < n; k++) begin
      res_valid = 1; res_data = 12'(base + k); step();
    end
    res_valid = 0;
  endtask

  task automatic read_reg(string tag, int a, int expv);
    rd_addr = a[3:0]; rd_en = 1; #1;
    chk(tag, rd_data, expv);
    step(); rd_en = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1: reset state
    chk("R1 cnt", conv_cnt, 0);
    chk("R1 flags", done_flags, 0);
    chk("R1 done", seq_done, 0);
    chk("R1 busy", busy, 0);
    // R1/R2: default length 4, indexed placement
    pulse_start();
    feed(4, 'h0A0);
    chk("R1 len4 done", seq_done, 1);
    chk("R8 busy low", busy, 0);
    chk("R1 len4 flags", done_flags, 'h000F);
    chk("R2 cnt back to 0", conv_cnt, 0);
    read_reg("R2 reg2", 2, 'h0A2);
    chk("R7 read clears", done_flags, 'h000B);
    // R4: length code 0 means 16
    config_set(0, 0);
    pulse_start();
    chk("R6 start clears flags", done_flags, 0);
    chk("R6 start clears done", seq_done, 0);
    feed(15, 'h200);
    chk("R4 not done at 15", seq_done, 0);
    feed(1, 'h20F);
    chk("R4 done at 16", seq_done, 1);
    chk("R4 all flags", done_flags, 'hFFFF);
    read_reg("R4 reg15", 15, 'h20F);
    // R8: scan restarts, R6 abort
    config_set(2, 0);
    scan = 1;
    pulse_start();
    feed(5, 'h100);
    chk("R8 scan busy", busy, 1);
    chk("R8 scan done", seq_done, 1);
    chk("R2 cnt pos", conv_cnt, 1);
    read_reg("R2 reg0 latest", 0, 'h104);
    pulse_abort();
    chk("R6 abort cnt", conv_cnt, 0);
    chk("R6 abort busy", busy, 0);
    chk("R6 abort keeps flags", done_flags, 'h0002);
    // R11: beats while idle are ignored
    feed(2, 'h7F0);
    chk("R11 idle cnt", conv_cnt, 0);
    chk("R11 idle flags", done_flags, 'h0002);
    read_reg("R11 idle reg0", 0, 'h104);
    // R5: ring mode across sequences with wrap
    config_set(5, 1);
    pulse_start();
    feed(7, 'h300);
    chk("R5 cnt keeps running", conv_cnt, 7);
    feed(10, 'h307);
    chk("R5 wrap", conv_cnt, 1);
    read_reg("R5 reg0 overwritten", 0, 'h310);
    read_reg("R5 reg15", 15, 'h30F);
    // R6: start in ring mode returns to 0
    pulse_start();
    chk("R6 ring start cnt", conv_cnt, 0);
    feed(1, 'h3A0);
    read_reg("R6 first to reg0", 0, 'h3A0);
    // R10: freeze holds
    freeze = 1; res_valid = 1; res_data = 'h555;
    #1 chk("R10 ready low", res_ready, 0);
    step(3);
    chk("R10 cnt held", conv_cnt, 1);
    freeze = 0;
    step();
    res_valid = 0;
    chk("R10 resume", conv_cnt, 2);
    read_reg("R10 resumed data", 1, 'h555);
    // R9: compare override
    cmp_en = 'hFFFF;
    step();
    chk("R9 ring forces off", cmp_en_eff, 0);
    config_set(4, 0);
    chk("R9 indexed passes", cmp_en_eff, 'hFFFF);
    scan = 0;
    // R7: write and read collide on same register
    pulse_start();
    feed(1, 'h400);
    rd_addr = 1; rd_en = 1; res_valid = 1; res_data = 'h401;
    step();
    rd_en = 0; res_valid = 0;
    chk("R7 set wins", done_flags, 'h0003);
    step(2);
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule